// File: doc/BRIEF.md
# Virtual JTAG Hub Responder

This block sits behind a physical TAP controller. It shares one scan path among several virtual debug nodes by means of two user instruction codes. The TAP supplies the current instruction register value, one-cycle Capture-DR, Shift-DR and Update-DR strobes, a test-logic-reset strobe and TDI. The hub drives a registered TDO.

When the "select" instruction is loaded, the data register works as a virtual instruction register (VIR). That register holds a node address in its upper bits and a command value in its lower bits. When the "access" instruction is loaded, the scan goes to one of three places. With address 0 and command 0, the hub reports about itself as a stream of 4-bit scans: first a configuration word, then one descriptor word per node. With a node address and the debug command, the scan goes to that node. Any other VIR content leaves the scan path inert.

The nodes are stub data registers. A node's address is its position in the descriptor stream.

Top module: `vjtag_hub`

## Requirements
- R1: After synchronous reset, tdo is 0. The VIR is zero, which selects the hub self-report. The nibble pointer stands at nibble 0 of the configuration word, and every node's stored data is zero.
- R2: With ir equal to SEL_CODE (default 0x0E), the data register is the VIR.
  - The VIR is {addr[AW-1:0], cmd[M_W-1:0]}, with AW = ceil(log2(NODES+1)).
  - Capture loads the current VIR into the shifter. Each shift enters tdi at the MSB and sends the LSB to tdo.
  - Update commits the shifter to the VIR. Without such an update, or a test-logic reset, the VIR does not change.
- R3: Shifting 64 zero bits under SEL_CODE and then updating selects address 0, command 0 (hub self-report), whatever the widths.
- R4: With ir equal to ACC_CODE (default 0x0C) and a VIR of zero, the nibble stream works as follows.
  - Each Capture-DR loads the current 4-bit nibble, which is shifted out LSB first.
  - Each Update-DR advances the pointer by one nibble.
  - Eight nibbles, least significant first, make one 32-bit word.
- R5: The configuration word is {version[4:0] = HUB_VER, node count[7:0], maker code[10:0] = 0x06E, M_W[7:0]}, from MSB down.
- R6: The configuration word is followed by one descriptor per node, in address order. Each descriptor is {NODE_VER[4:0], node ID[7:0], 0x06E[10:0], instance = address-1 [7:0]}. After the last descriptor, the stream wraps to the configuration word.
- R7: When the VIR holds address k (1..NODES) and command DBG_CMD (default 0x8), ACC_CODE scans reach node k's DR_W-bit register. Capture loads the stored value, which is shifted out LSB first. Update stores the bits shifted in.
- R8: A tlr pulse clears the VIR to zero and rewinds the nibble pointer to the start of the configuration word. Node data is kept.
- R9: Under ACC_CODE, an address above NODES, a node address with a command other than DBG_CMD, or address 0 with a non-zero command each give tdo = 0. Such scans change no node data and do not move the nibble pointer.
- R10: Every committed VIR update rewinds the nibble pointer to the start of the configuration word.
- R11: In the cycle after a shift edge, tdo holds the bit that left the selected register. In every other cycle it is 0. Under an ir code other than the two user codes, tdo is 0 and no hub state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | Test-logic-reset strobe from the TAP |
| ir | input | IR_W | Physical instruction register value |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Registered serial data out |

## Verification
The only output, tdo, is registered. The bit that leaves a register at a shift edge therefore appears after that same edge. The bench drives strobes on the falling edge and samples tdo at the next falling edge, so the k-th sample of a scan is bit k of the value loaded at Capture.

VIR commits, node stores and nibble-pointer moves take effect at the Update edge. The bench only observes them through a later scan, which means at least two cycles afterwards. Each expected word or node value comes from bench functions and from a model array updated at the same Update points.

// File: rtl/vjh_pkg.sv
package vjh_pkg;
  localparam logic [10:0] MAKER_CODE = 11'h06E;
  localparam int          NIBS       = 8;

  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_VIR  = 2'd1,
    PATH_INFO = 2'd2,
    PATH_NODE = 2'd3
  } path_e;

  function automatic logic [31:0] info_word(input logic [4:0] ver,
                                            input logic [7:0] mid,
                                            input logic [7:0] low);
    return {ver, mid, MAKER_CODE, low};
  endfunction
endpackage

// File: rtl/vjh_vir.sv
module vjh_vir #(
  parameter int VIR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tlr,
  input  logic             sel,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tdi,
  output logic             so,
  output logic             committed,
  output logic [VIR_W-1:0] vir_q
);
  logic [VIR_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || tlr) begin
      sh    <= '0;
      vir_q <= '0;
    end else if (sel) begin
      if (capture)    sh <= vir_q;
      else if (shift) sh <= {tdi, sh[VIR_W-1:1]};
      if (update)     vir_q <= sh;
    end
  end

  assign so        = sh[0];
  assign committed = sel && update && !rst && !tlr;
endmodule

// File: rtl/vjh_info.sv
module vjh_info
  import vjh_pkg::*;
#(
  parameter int               NODES    = 2,
  parameter int               M_W      = 4,
  parameter logic [4:0]       HUB_VER  = 5'd1,
  parameter logic [4:0]       NODE_VER = 5'd1,
  parameter logic [NODES*8-1:0] NODE_IDS = 16'h8408
) (
  input  logic clk,
  input  logic rst,
  input  logic rewind,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic update,
  output logic so
);
  localparam int WI_W = $clog2(NODES + 1);

  logic [WI_W-1:0] word_idx;
  logic [2:0]      nib_idx;
  logic [3:0]      nsh;
  logic [31:0]     word;
  logic [3:0]      nibble;

  always_comb begin
    word = info_word(HUB_VER, 8'(NODES), 8'(M_W));
    for (int k = 1; k <= NODES; k++) begin
      if (word_idx == WI_W'(k))
        word = info_word(NODE_VER, NODE_IDS[(k-1)*8 +: 8], 8'(k - 1));
    end
    nibble = word[nib_idx*4 +: 4];
  end

  always_ff @(posedge clk) begin
    if (rst || rewind) begin
      word_idx <= '0;
      nib_idx  <= '0;
      nsh      <= '0;
    end else if (sel) begin
      if (capture)    nsh <= nibble;
      else if (shift) nsh <= {1'b0, nsh[3:1]};
      if (update) begin
        nib_idx <= nib_idx + 3'd1;
        if (nib_idx == 3'(NIBS - 1))
          word_idx <= (word_idx == WI_W'(NODES)) ? '0 : word_idx + WI_W'(1);
      end
    end
  end

  assign so = nsh[0];
endmodule

// File: rtl/vjh_node.sv
module vjh_node #(
  parameter int DR_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic tdi,
  output logic so
);
  logic [DR_W-1:0] sh;
  logic [DR_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      held <= '0;
    end else if (sel) begin
      if (capture)    sh <= held;
      else if (shift) sh <= {tdi, sh[DR_W-1:1]};
      if (update)     held <= sh;
    end
  end

  assign so = sh[0];
endmodule

// File: rtl/vjtag_hub.sv
module vjtag_hub
  import vjh_pkg::*;
#(
  parameter int                 IR_W     = 10,
  parameter logic [IR_W-1:0]    SEL_CODE = 10'h00E,
  parameter logic [IR_W-1:0]    ACC_CODE = 10'h00C,
  parameter int                 NODES    = 2,
  parameter int                 M_W      = 4,
  parameter int                 DBG_CMD  = 8,
  parameter int                 DR_W     = 8,
  parameter logic [4:0]         HUB_VER  = 5'd1,
  parameter logic [4:0]         NODE_VER = 5'd1,
  parameter logic [NODES*8-1:0] NODE_IDS = 16'h8408
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tlr,
  input  logic [IR_W-1:0] ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo
);
  localparam int AW    = $clog2(NODES + 1);
  localparam int VIR_W = AW + M_W;

  logic             is_sel, is_acc;
  logic             vir_so, vir_commit, info_so, hub_sel;
  logic [VIR_W-1:0] vir_q;
  logic [AW-1:0]    vir_addr;
  logic [M_W-1:0]   vir_cmd;
  logic [NODES-1:0] node_sel, node_so;
  path_e            path;
  logic             out_bit;

  assign is_sel   = (ir == SEL_CODE);
  assign is_acc   = (ir == ACC_CODE);
  assign vir_addr = vir_q[VIR_W-1:M_W];
  assign vir_cmd  = vir_q[M_W-1:0];
  assign hub_sel  = is_acc && (vir_q == '0);

  vjh_vir #(.VIR_W(VIR_W)) u_vir (
    .clk(clk), .rst(rst), .tlr(tlr), .sel(is_sel),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
    .so(vir_so), .committed(vir_commit), .vir_q(vir_q)
  );

  vjh_info #(
    .NODES(NODES), .M_W(M_W), .HUB_VER(HUB_VER),
    .NODE_VER(NODE_VER), .NODE_IDS(NODE_IDS)
  ) u_info (
    .clk(clk), .rst(rst), .rewind(tlr || vir_commit), .sel(hub_sel),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr),
    .so(info_so)
  );

  for (genvar g = 0; g < NODES; g++) begin : g_node
    assign node_sel[g] = is_acc && (vir_addr == AW'(g + 1))
                         && (vir_cmd == M_W'(DBG_CMD));
    vjh_node #(.DR_W(DR_W)) u_node (
      .clk(clk), .rst(rst), .sel(node_sel[g]),
      .capture(capture_dr), .shift(shift_dr), .update(update_dr),
      .tdi(tdi), .so(node_so[g])
    );
  end

  always_comb begin
    if (is_sel)            path = PATH_VIR;
    else if (hub_sel)      path = PATH_INFO;
    else if (|node_sel)    path = PATH_NODE;
    else                   path = PATH_NONE;
    case (path)
      PATH_VIR:  out_bit = vir_so;
      PATH_INFO: out_bit = info_so;
      PATH_NODE: out_bit = |(node_sel & node_so);
      default:   out_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tdo <= 1'b0;
    else     tdo <= shift_dr ? out_bit : 1'b0;
  end
endmodule

// File: rtl/vjtag_hub_chk.sv
module vjtag_hub_chk #(
  parameter int              IR_W     = 10,
  parameter logic [IR_W-1:0] SEL_CODE = 10'h00E,
  parameter logic [IR_W-1:0] ACC_CODE = 10'h00C,
  parameter int              NODES    = 2,
  parameter int              M_W      = 4,
  parameter int              VIR_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             tlr,
  input logic [IR_W-1:0]  ir,
  input logic             shift_dr,
  input logic             update_dr,
  input logic             tdo,
  input logic [VIR_W-1:0] vir_q
);
  // R11
  tdo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_dr |=> !tdo);

  // R11
  tdo_foreign_ir_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_dr && ir != SEL_CODE && ir != ACC_CODE) |=> !tdo);

  // R9
  tdo_absent_node_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_dr && ir == ACC_CODE && int'(vir_q[VIR_W-1:M_W]) > NODES) |=> !tdo);

  // R8
  tlr_clears_vir_chk: assert property (@(posedge clk) disable iff (rst)
    tlr |=> (vir_q == '0));

  // R2
  vir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(update_dr && ir == SEL_CODE) && !tlr) |=> $stable(vir_q));
endmodule

bind vjtag_hub vjtag_hub_chk #(
  .IR_W(IR_W), .SEL_CODE(SEL_CODE), .ACC_CODE(ACC_CODE),
  .NODES(NODES), .M_W(M_W), .VIR_W(VIR_W)
) u_chk (
  .clk(clk), .rst(rst), .tlr(tlr), .ir(ir), .shift_dr(shift_dr),
  .update_dr(update_dr), .tdo(tdo), .vir_q(vir_q)
);

// File: tb/sim_vjtag_hub.sv
module sim_vjtag_hub;
  localparam int          CLK_PERIOD = 10;
  localparam logic [9:0]  SEL = 10'h00E;
  localparam logic [9:0]  ACC = 10'h00C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tlr = 1'b0;
  logic [9:0] ir  = '0;
  logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic       tdo;

  int vectors = 0;
  int fails   = 0;
  logic [7:0] model [1:2];

  always #(CLK_PERIOD/2) clk = ~clk;

  vjtag_hub u0 (
    .clk(clk), .rst(rst), .tlr(tlr), .ir(ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
  );

  function automatic logic [31:0] cfg_word();
    return {5'd1, 8'd2, 11'h06E, 8'd4};
  endfunction

  function automatic logic [31:0] node_word(input int k);
    logic [7:0] id;
    id = (k == 1) ? 8'h08 : 8'h84;
    return {5'd1, id, 11'h06E, 8'(k - 1)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic scan(input int len, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    capture_dr = 1'b1; @(negedge clk); capture_dr = 1'b0;
    for (int i = 0; i < len; i++) begin
      shift_dr = 1'b1; tdi = din[i];
      @(negedge clk);
      dout[i] = tdo;
    end
    shift_dr = 1'b0; tdi = 1'b0;
    update_dr = 1'b1; @(negedge clk); update_dr = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_vir(input logic [1:0] addr, input logic [3:0] cmd, output logic [5:0] old);
    logic [63:0] d;
    ir = SEL;
    scan(6, {58'd0, addr, cmd}, d);
    old = d[5:0];
  endtask

  task automatic read_nibs(input int cnt, output logic [31:0] w);
    logic [63:0] d;
    w = '0;
    ir = ACC;
    for (int i = 0; i < cnt; i++) begin
      scan(4, 64'd0, d);
      w[i*4 +: 4] = d[3:0];
    end
  endtask

  task automatic node_xfer(input int k, input logic [7:0] v, input string req);
    logic [5:0] o;
    logic [63:0] d;
    set_vir(2'(k), 4'h8, o);
    ir = ACC;
    scan(8, {56'd0, v}, d);
    check(req, d[7:0], model[k]);
    model[k] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [5:0]  o;
    logic [31:0] w;
    logic [63:0] d;
    void'($urandom(32'd20517));
    model[1] = 8'h00; model[2] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 tdo", {63'd0, tdo}, 64'd0);
    set_vir(2'd0, 4'd0, o);
    check("R1 vir", {58'd0, o}, 64'd0);
    read_nibs(8, w);
    check("R1/R5 cfg", {32'd0, w}, {32'd0, cfg_word()});

    // R2 / R3: load garbage, then a 64-zero shift
    set_vir(2'd1, 4'h8, o);
    ir = SEL;
    scan(64, 64'd0, d);
    check("R2 vir readback", {58'd0, d[5:0]}, 64'h18);
    read_nibs(8, w);
    check("R3/R4/R5 cfg after zeros", {32'd0, w}, {32'd0, cfg_word()});

    // R6: node descriptors and wrap
    read_nibs(8, w);
    check("R6 node1", {32'd0, w}, {32'd0, node_word(1)});
    read_nibs(8, w);
    check("R6 node2", {32'd0, w}, {32'd0, node_word(2)});
    read_nibs(8, w);
    check("R6 wrap", {32'd0, w}, {32'd0, cfg_word()});

    // R10: VIR update rewinds
    read_nibs(3, w);
    set_vir(2'd0, 4'd0, o);
    read_nibs(8, w);
    check("R10 rewind", {32'd0, w}, {32'd0, cfg_word()});

    // R8: tlr rewinds pointer and clears VIR
    read_nibs(2, w);
    tlr = 1'b1; @(negedge clk); tlr = 1'b0; @(negedge clk);
    read_nibs(8, w);
    check("R8 pointer", {32'd0, w}, {32'd0, cfg_word()});

    // R7: node access
    node_xfer(1, 8'hA5, "R7 node1 first");
    node_xfer(2, 8'h3C, "R7 node2 first");
    node_xfer(1, 8'h5A, "R7 node1 readback");
    node_xfer(2, 8'hC3, "R7 node2 readback");

    set_vir(2'd1, 4'h8, o);
    tlr = 1'b1; @(negedge clk); tlr = 1'b0; @(negedge clk);
    set_vir(2'd0, 4'd0, o);
    check("R8 vir cleared", {58'd0, o}, 64'd0);
    node_xfer(1, 8'h11, "R8 node data kept");

    // R9: inert selections
    set_vir(2'd3, 4'h8, o);
    ir = ACC; scan(8, 64'hFF, d);
    check("R9 absent addr tdo", d, 64'd0);
    set_vir(2'd1, 4'h5, o);
    ir = ACC; scan(8, 64'hFF, d);
    check("R9 wrong cmd tdo", d, 64'd0);
    set_vir(2'd0, 4'h3, o);
    ir = ACC; scan(8, 64'hFF, d);
    check("R9 hub nonzero cmd tdo", d, 64'd0);
    node_xfer(1, 8'h22, "R9 node1 untouched");

    // R11: foreign IR leaves pointer in place, tdo zero
    set_vir(2'd0, 4'd0, o);
    read_nibs(2, w);
    ir = 10'h003; scan(8, 64'hFF, d);
    check("R11 foreign ir tdo", d, 64'd0);
    begin
      logic [31:0] w2;
      read_nibs(6, w2);
      check("R11 pointer held", {32'd0, w[7:0] | (w2 << 8)}, {32'd0, cfg_word()});
    end
    check("R11 idle tdo", {63'd0, tdo}, 64'd0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int unsigned r;
      r = $urandom % 4;
      if (r < 2) begin
        node_xfer(int'(r) + 1, 8'($urandom), "R7 random node");
      end else if (r == 2) begin
        set_vir(2'd3, 4'($urandom), o);
        ir = ACC; scan(8, 64'($urandom), d);
        check("R9 random absent", d, 64'd0);
      end else begin
        set_vir(2'd0, 4'd0, o);
        read_nibs(8, w);
        check("R4 random cfg", {32'd0, w}, {32'd0, cfg_word()});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule